// File: doc/BRIEF.md
# Exclusive Two-Port Handshake Merge

This block joins two four-phase request/acknowledge channels onto one outgoing four-phase channel. The two incoming channels are promised to be mutually exclusive. When one of them raises its request and the merge is idle, the block acknowledges that channel and raises the outgoing request in the same clock cycle. The outgoing request drops as soon as the far side acknowledges it.

The incoming channel's return-to-zero runs independently of the outgoing channel. Its acknowledge is held while its request stays high and is released one cycle after the request falls, whatever the outgoing side is doing. A fresh request on either input may therefore arrive while the outgoing handshake is still finishing. Such a request waits until the outgoing acknowledge has fallen and both input acknowledges are low. The block decides this from the acknowledge levels alone and keeps no extra state bit to tell "idle" from "just finished".

A sticky flag reports any cycle in which both input requests are high. Such a cycle is never granted. All outputs are registered and reset to zero.

Top module: `hs_merge2`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, ack_a, ack_b, out_req and excl_err are all 0.
- R2: When ack_a, ack_b, out_req and out_ack are all low and exactly one input request is high, the acknowledge of that input and out_req are both 1 at the next clock edge.
- R3: out_req, once high, falls at the clock edge after out_ack is sampled high, and stays high until then.
- R4: An input acknowledge stays high while its request is high, and falls at the clock edge after its request is sampled low.
- R5: No input acknowledge rises while out_req, out_ack or the other input acknowledge is high. A request that arrives then is granted at the first edge after all three are low.
- R6: out_req shows exactly one rising edge for each input request.
- R7: ack_a and ack_b are never high together.
- R8: excl_err becomes 1 at the clock edge after req_a and req_b are sampled high together, and stays 1 until reset. A cycle with both requests high grants neither input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_a | input | 1 | Request of input channel A |
| req_b | input | 1 | Request of input channel B |
| out_ack | input | 1 | Acknowledge of the outgoing channel |
| ack_a | output | 1 | Acknowledge to input channel A |
| ack_b | output | 1 | Acknowledge to input channel B |
| out_req | output | 1 | Request of the outgoing channel |
| excl_err | output | 1 | Sticky flag: both input requests were seen high together |

## Verification
The hardest case to reach is a new request that arrives while the outgoing handshake is still open, after the previous input has already returned to zero. It must be held back without being lost or served twice. The stimulus sweeps every order of ports over four back-to-back transactions. It also varies the outgoing acknowledge's rise and fall delays, the input hold time and the gap between requests. Zero delays push the next request into the window where out_req or out_ack is still high. Each run then compares the number of out_req pulses with the number of requests issued.

// File: rtl/hs_merge2.sv
module hs_merge2 (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  input  logic out_ack,
  output logic ack_a,
  output logic ack_b,
  output logic out_req,
  output logic excl_err
);

  logic idle;
  logic take_a;
  logic take_b;

  assign idle   = !ack_a && !ack_b && !out_req && !out_ack;
  assign take_a = idle && req_a && !req_b;
  assign take_b = idle && req_b && !req_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_a    <= 1'b0;
      ack_b    <= 1'b0;
      out_req  <= 1'b0;
      excl_err <= 1'b0;
    end else begin
      ack_a    <= ack_a ? req_a : take_a;
      ack_b    <= ack_b ? req_b : take_b;
      out_req  <= out_req ? !out_ack : (take_a || take_b);
      excl_err <= excl_err || (req_a && req_b);
    end
  end

  a_r2_grant_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_a && !ack_b && !out_req && !out_ack && req_a && !req_b) |=> (ack_a && out_req));
  a_r2_grant_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_a && !ack_b && !out_req && !out_ack && req_b && !req_a) |=> (ack_b && out_req));
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && out_ack) |=> !out_req);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> out_req);
  a_r4_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_a && req_a) |=> ack_a);
  a_r4_drop_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_a && !req_a) |=> !ack_a);
  a_r4_drop_b: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_b && !req_b) |=> !ack_b);
  a_r5_wait_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_a && (out_req || out_ack || ack_b)) |=> !ack_a);
  a_r5_wait_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_b && (out_req || out_ack || ack_a)) |=> !ack_b);
  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_a && ack_b));
  a_r8_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_a && req_b) |=> excl_err);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    excl_err |=> excl_err);

endmodule

// File: tb/test_hs_merge2.sv
module test_hs_merge2;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_a = 1'b0, req_b = 1'b0, out_ack = 1'b0;
  logic ack_a, ack_b, out_req, excl_err;

  hs_merge2 i_hs_merge2 (
    .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b), .out_ack(out_ack),
    .ack_a(ack_a), .ack_b(ack_b), .out_req(out_req), .excl_err(excl_err)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic e_aa = 0, e_ab = 0, e_r = 0, e_err = 0;
  logic prev_r = 0;
  int pulses;

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic cycle();
    logic idle, ga, gb;
    @(posedge clk);
    idle = !e_aa && !e_ab && !e_r && !out_ack;
    ga = idle && req_a && !req_b;
    gb = idle && req_b && !req_a;
    e_r   = e_r ? !out_ack : (ga || gb);
    e_aa  = e_aa ? req_a : ga;
    e_ab  = e_ab ? req_b : gb;
    e_err = e_err || (req_a && req_b);
    @(negedge clk);
    chk(ack_a, e_aa, "R2 R4 R5 ack_a");
    chk(ack_b, e_ab, "R2 R4 R5 ack_b");
    chk(out_req, e_r, "R3 R5 out_req");
    chk(excl_err, e_err, "R8 excl_err");
    chk(ack_a && ack_b, 1'b0, "R7 both acks");
    if (out_req && !prev_r) pulses++;
    prev_r = out_req;
  endtask

  initial begin
    #(PERIOD*150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ack_a, 0, "R1 ack_a"); chk(ack_b, 0, "R1 ack_b");
    chk(out_req, 0, "R1 out_req"); chk(excl_err, 0, "R1 excl_err");
    rst_n = 1'b1;
    cycle();
    chk(out_req, 0, "R1 out_req after reset");

    for (int pat = 0; pat < 16; pat++)
      for (int k = 0; k < 3; k++)
        for (int m = 0; m < 3; m++)
          for (int j = 0; j < 2; j++)
            for (int g = 0; g < 2; g++) begin
              int t, ph, gc, hc, kc, mc, issued, guard, p;
              bit busy;
              t = 0; ph = 0; gc = 0; hc = 0; kc = 0; mc = 0; issued = 0; guard = 0; p = 0;
              pulses = 0;
              busy = 1;
              while (busy && guard < 400) begin
                guard++;
                cycle();
                if (out_req && !out_ack) begin
                  if (kc >= k) begin out_ack = 1; kc = 0; end else kc++;
                end else if (!out_req && out_ack) begin
                  if (mc >= m) begin out_ack = 0; mc = 0; end else mc++;
                end
                case (ph)
                  0: if (t < 4) begin
                       if (gc >= g) begin
                         p = (pat >> t) & 1;
                         if (p == 0) req_a = 1; else req_b = 1;
                         issued++; ph = 1; hc = 0;
                       end else gc++;
                     end
                  1: if ((p == 0) ? ack_a : ack_b) begin
                       if (hc >= j) begin
                         if (p == 0) req_a = 0; else req_b = 0;
                         ph = 2;
                       end else hc++;
                     end
                  default: if (!((p == 0) ? ack_a : ack_b)) begin
                       t++; ph = 0; gc = 0;
                     end
                endcase
                busy = (t < 4) || ack_a || ack_b || out_req || out_ack || req_a || req_b;
              end
              chk(guard < 400, 1'b1, "R5 sequence drained");
              checks++;
              if (pulses != issued) begin
                fails++;
                $display("FAIL R6 pulse count: actual %0d expected %0d (pat %0d)", pulses, issued, pat);
              end
            end

    req_a = 1; req_b = 1;
    cycle();
    chk(excl_err, 1, "R8 flag set");
    chk(ack_a || ack_b || out_req, 0, "R8 no grant on clash");
    req_a = 0; req_b = 0;
    repeat (3) cycle();
    chk(excl_err, 1, "R8 flag sticky");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule